// File: doc/BRIEF.md
# Multi-Mode Operand Shifter

This block is the shifting unit of a DSP datapath's arithmetic/logic stage. One operand word goes in together with a shift count, a three-bit operation code and the current carry flag. One clock later the block presents the shifted word and the new carry flag. It offers two right shifts (sign-filling and zero-filling), a zero-filling left shift, rotations in both directions, and single-step rotations through the carry flag.

All movement is done by one right-shifting network. That network is a chain of binary-weighted stages, and the lowest bit of the count drives the first stage. Bits entering from the top of the word come from a separate fill word. A small decode picks the fill word for each operation: copies of the sign bit, zeros, the operand itself for rotation, or the carry flag for carry rotation. Left-moving operations mirror the operand before the network and mirror the result after it, so a single network serves both directions.

Top module: `alu_shifter`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a rising clock edge, `result` and `carry_out` become 0.
- R2: Op code 0 (arithmetic right) shifts `operand` right by `amount` places and fills the vacated upper places with copies of operand bit 15.
- R3: Op code 1 (logical right) shifts right by `amount` places and fills the vacated upper places with zeros.
- R4: Op code 2 (logical left) shifts left by `amount` places and fills the vacated lower places with zeros.
- R5: Op code 3 rotates right by `amount` places and op code 4 rotates left by `amount` places, without the carry flag. Every bit that leaves one end enters at the other end.
- R6: Op code 5 rotates right through carry by exactly one place, whatever `amount` holds. `carry_in` enters bit 15 and operand bit 0 becomes `carry_out`.
- R7: Op code 6 rotates left through carry by exactly one place, whatever `amount` holds. `carry_in` enters bit 0 and operand bit 15 becomes `carry_out`.
- R8: For op codes 0 to 4 with a nonzero `amount`, `carry_out` is the last bit shifted out. That is operand bit amount-1 for right moves and operand bit 16-amount for left moves.
- R9: For op codes 0 to 4 with `amount` equal to 0, `result` equals `operand` and `carry_out` equals `carry_in`.
- R10: Op code 7 (pass) gives `result` equal to `operand` and `carry_out` equal to `carry_in`, whatever `amount` holds.
- R11: Outputs are registered. The effect of the inputs sampled at one rising edge appears on `result` and `carry_out` right after that edge and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| operand | input | 16 | Word to be shifted or rotated |
| amount | input | 4 | Shift count, 0 to 15 |
| op | input | 3 | Operation code (0 ASR, 1 LSR, 2 LSL, 3 ROR, 4 ROL, 5 RORC, 6 ROLC, 7 pass) |
| carry_in | input | 1 | Current carry flag |
| result | output | 16 | Registered shifted word |
| carry_out | output | 1 | Registered updated carry flag |

## Verification
The bench builds the block with its default parameters: a 16-bit word and a 4-bit count. The count can therefore take every value from 0 to 15, and every stage of the shift network, alone and combined, is reachable. Directed passes apply each operation at counts 0, 1, 8 and 15 to sign-set, sign-clear, alternating and single-bit words. These passes hit the fill boundaries, the zero-count carry hold and the counts that carry-rotation must ignore. A further run of pseudo-random inputs covers mixed combinations of all of these.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [2:0] {
    SH_ASR  = 3'd0,
    SH_LSR  = 3'd1,
    SH_LSL  = 3'd2,
    SH_ROR  = 3'd3,
    SH_ROL  = 3'd4,
    SH_RORC = 3'd5,
    SH_ROLC = 3'd6,
    SH_PASS = 3'd7
  } shf_op_e;

  function automatic logic op_is_left(input shf_op_e o);
    return (o == SH_LSL) || (o == SH_ROL) || (o == SH_ROLC);
  endfunction

  function automatic logic op_is_carry_rot(input shf_op_e o);
    return (o == SH_RORC) || (o == SH_ROLC);
  endfunction

endpackage

// File: rtl/shf_bitrev.sv
module shf_bitrev #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign dout[i] = din[WIDTH-1-i];
  end
endmodule

// File: rtl/shf_fill_gen.sv
module shf_fill_gen
  import shf_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int FILL_W = WIDTH - 1
) (
  input  shf_op_e           op,
  input  logic [WIDTH-1:0]  src,
  input  logic              cin,
  output logic [FILL_W-1:0] fill
);
  always_comb begin
    fill = '0;
    unique case (op)
      SH_ASR:           fill = {FILL_W{src[WIDTH-1]}};
      SH_ROR, SH_ROL:   fill = src[FILL_W-1:0];
      SH_RORC, SH_ROLC: fill = {{(FILL_W-1){1'b0}}, cin};
      default:          fill = '0;
    endcase
  end
endmodule

// File: rtl/shf_rshift_core.sv
module shf_rshift_core #(
  parameter int WIDTH  = 16,
  parameter int AMT_W  = $clog2(WIDTH),
  parameter int FILL_W = WIDTH - 1
) (
  input  logic [WIDTH-1:0]  data,
  input  logic [FILL_W-1:0] fill,
  input  logic [AMT_W-1:0]  amt,
  output logic [WIDTH-1:0]  res,
  output logic              last_out
);
  localparam int VW = FILL_W + WIDTH + 1;

  logic [VW-1:0] stg [0:AMT_W];

  assign stg[0] = {fill, data, 1'b0};

  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    assign stg[k+1] = amt[k] ? (stg[k] >> (1 << k)) : stg[k];
  end

  assign res      = stg[AMT_W][WIDTH:1];
  assign last_out = stg[AMT_W][0];
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import shf_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] operand,
  input  logic [AMT_W-1:0] amount,
  input  logic [2:0]       op,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  localparam int FILL_W = WIDTH - 1;

  shf_op_e           op_e;
  logic              left;
  logic [WIDTH-1:0]  mirrored;
  logic [WIDTH-1:0]  core_in;
  logic [FILL_W-1:0] fill;
  logic [AMT_W-1:0]  eff_amt;
  logic [WIDTH-1:0]  core_out;
  logic [WIDTH-1:0]  core_out_mir;
  logic              shout;
  logic [WIDTH-1:0]  res_d;
  logic              cy_d;

  assign op_e    = shf_op_e'(op);
  assign left    = op_is_left(op_e);
  assign eff_amt = op_is_carry_rot(op_e) ? AMT_W'(1) : amount;

  shf_bitrev #(.WIDTH(WIDTH)) u_rev_in (
    .din  (operand),
    .dout (mirrored)
  );

  assign core_in = left ? mirrored : operand;

  shf_fill_gen #(.WIDTH(WIDTH), .FILL_W(FILL_W)) u_fill (
    .op   (op_e),
    .src  (core_in),
    .cin  (carry_in),
    .fill (fill)
  );

  shf_rshift_core #(.WIDTH(WIDTH), .AMT_W(AMT_W), .FILL_W(FILL_W)) u_core (
    .data     (core_in),
    .fill     (fill),
    .amt      (eff_amt),
    .res      (core_out),
    .last_out (shout)
  );

  shf_bitrev #(.WIDTH(WIDTH)) u_rev_out (
    .din  (core_out),
    .dout (core_out_mir)
  );

  always_comb begin
    if (op_e == SH_PASS || eff_amt == '0) begin
      res_d = operand;
      cy_d  = carry_in;
    end else begin
      res_d = left ? core_out_mir : core_out;
      cy_d  = shout;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      result    <= res_d;
      carry_out <= cy_d;
    end
  end
endmodule

// File: rtl/alu_shifter_chk.sv
module alu_shifter_chk #(
  parameter int WIDTH = 16,
  parameter int AMT_W = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] operand,
  input logic [AMT_W-1:0] amount,
  input logic [2:0]       op,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  // R10
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd7) |=> (result == $past(operand)) && (carry_out == $past(carry_in)));

  // R9
  zero_count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op < 3'd5 && amount == '0) |=> (result == $past(operand)) && (carry_out == $past(carry_in)));

  // R6
  rot_right_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd5) |=> (result == {$past(carry_in), $past(operand[WIDTH-1:1])})
                     && (carry_out == $past(operand[0])));

  // R7
  rot_left_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd6) |=> (result == {$past(operand[WIDTH-2:0]), $past(carry_in)})
                     && (carry_out == $past(operand[WIDTH-1])));

  // R2
  sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd0) |=> (result[WIDTH-1] == $past(operand[WIDTH-1])));

  // R5
  rotate_weight_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd3 || op == 3'd4) |=> ($countones(result) == $countones($past(operand))));
endmodule

bind alu_shifter alu_shifter_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .operand   (operand),
  .amount    (amount),
  .op        (op),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/alu_shifter_bench.sv
module alu_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 4;

  typedef struct {
    logic [DW-1:0] res;
    logic          cy;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] operand = '0;
  logic [AW-1:0] amount = '0;
  logic [2:0]    op = 3'd7;
  logic          carry_in = 1'b0;
  logic [DW-1:0] result;
  logic          carry_out;

  int checks = 0;
  int fails = 0;
  exp_t exp_q [$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_shifter #(.WIDTH(DW), .AMT_W(AW)) u_alu_shifter (
    .clk(clk), .rst(rst), .operand(operand), .amount(amount), .op(op),
    .carry_in(carry_in), .result(result), .carry_out(carry_out)
  );

  function automatic void model(input logic [DW-1:0] x, input int n, input int o,
                                input logic ci, output logic [DW-1:0] r,
                                output logic c, output string tag);
    logic [2*DW-1:0] t;
    r = x; c = ci; tag = "R10";
    case (o)
      0: begin r = DW'($signed(x) >>> n); tag = "R2"; end
      1: begin r = x >> n; tag = "R3"; end
      2: begin r = x << n; tag = "R4"; end
      3: begin t = {x, x} >> n; r = t[DW-1:0]; tag = "R5"; end
      4: begin t = {x, x} << n; r = t[2*DW-1:DW]; tag = "R5"; end
      5: begin r = {ci, x[DW-1:1]}; c = x[0]; tag = "R6"; end
      6: begin r = {x[DW-2:0], ci}; c = x[DW-1]; tag = "R7"; end
      default: ;
    endcase
    if (o <= 4) begin
      if (n == 0) begin r = x; c = ci; tag = "R9"; end
      else if (o == 2 || o == 4) begin c = x[DW-n]; tag = {tag, "/R8"}; end
      else begin c = x[n-1]; tag = {tag, "/R8"}; end
    end
  endfunction

  task automatic drive(input logic [DW-1:0] x, input int n, input int o, input logic ci);
    exp_t e;
    @(negedge clk);
    operand = x; amount = AW'(n); op = 3'(o); carry_in = ci;
    model(x, n, o, ci, e.res, e.cy, e.tag);
    e.tag = {e.tag, "/R11"};
    exp_q.push_back(e);
  endtask

  // Monitor: item pushed at a negedge is captured at the next posedge.
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        #(CLK_PERIOD/4);
        checks++;
        if (result !== e.res || carry_out !== e.cy) begin
          fails++;
          $display("FAIL %s: result=%h cy=%b expected result=%h cy=%b",
                   e.tag, result, carry_out, e.res, e.cy);
        end
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] pats [4];
    int amts [4];
    pats[0] = 16'h8001; pats[1] = 16'h7FFE; pats[2] = 16'hA5C3; pats[3] = 16'h0100;
    amts[0] = 0; amts[1] = 1; amts[2] = 8; amts[3] = 15;

    // R1: reset state
    operand = 16'hFFFF; amount = 4'd3; op = 3'd0; carry_in = 1'b1;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    checks++;
    if (result !== '0 || carry_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: result=%h cy=%b expected result=0000 cy=0", result, carry_out);
    end
    @(negedge clk);
    rst = 1'b0;

    for (int o = 0; o < 8; o++)
      for (int p = 0; p < 4; p++)
        for (int a = 0; a < 4; a++)
          for (int ci = 0; ci < 2; ci++)
            drive(pats[p], amts[a], o, 1'(ci));

    for (int i = 0; i < 400; i++)
      drive(DW'($urandom), int'($urandom_range(0, 15)), int'($urandom_range(0, 7)),
            1'($urandom));

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule